// File: doc/BRIEF.md
# Real-Mode Interrupt Entry and Return Sequencer

This block carries out the stack and vector-table traffic of a real-mode interrupt. When it is idle it accepts an operation request: a numbered software interrupt, the one-byte breakpoint, the overflow trap, an array-bound check, an interrupt return, or setting or clearing of the interrupt-enable flag. It also accepts an external maskable interrupt, but only while the interrupt-enable flag is set. The block owns the CS, IP, SP and FLAGS registers. It performs every memory access through a single 16-bit word port that has a ready handshake. Each access uses a 20-bit byte address formed as segment × 16 + offset.

An interrupt entry first stores FLAGS, CS and IP on the stack at SS:SP. It then reads the new IP and CS from the vector table at the bottom of memory, where each vector occupies four bytes. An interrupt return pops the three words in the opposite order. The owning pipeline supplies the address of the next instruction with each request, and for a trapping instruction that address is the return address pushed on the stack. The block pulses a done strobe when an operation finishes. It ignores all requests while a sequence is in progress.

Top module: `rm_int_unit`

## Requirements
- R1: An entry through vector v reads the word at byte address 4·v as the new IP and the word at 4·v+2 as the new CS, and loads both. Vector 255 uses addresses 0x3FC and 0x3FE.
- R2: An entry writes three words at SS:SP−2, SS:SP−4 and SS:SP−6, in this order: FLAGS, CS, IP. The pushed IP is the next-instruction address of the request, or the current IP for an external interrupt. SP drops by 2 on each push and wraps within the 16-bit offset.
- R3: After the FLAGS push, trace (bit 8) and interrupt-enable (bit 9) are 0. The pushed FLAGS word holds their earlier values.
- R4: Operation code 1 (breakpoint) enters through vector 3 whatever the vector input carries.
- R5: Operation code 2 (overflow trap) with overflow flag bit 11 at 0 makes no memory access, sets IP to the next-instruction address and signals done. With bit 11 at 1 it enters through vector 4.
- R6: Operation code 3 (bound check) reads a signed lower word at the given segment:offset and a signed upper word at offset+2. A value below the lower word or above the upper word enters through vector 5. Otherwise IP becomes the next-instruction address and the block signals done.
- R7: Operation code 4 (return) reads IP, then CS, then FLAGS from SS:SP upward, with SP rising by 2 per read.
- R8: Operation code 5 sets and code 6 clears FLAGS bit 9, and each sets IP to the next-instruction address. The external interrupt is accepted from idle only when bit 9 is 1. Operation code 0 enters through the vector input.
- R9: A memory request holds its address, direction and write data unchanged until ready is seen.
- R10: done_o is a one-cycle pulse at the end of every operation. Operation requests, external interrupts and loads that arrive while busy_o is high have no effect.
- R11: Reset gives CS=0xFFFF, IP=0, SP=0 and FLAGS=0x0002. A load while idle replaces all four registers.
- R12: Operation code 7 is ignored: no access, no done, no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ld_i | input | 1 | load the architectural registers (idle only) |
| ld_cs_i | input | 16 | CS value for a load |
| ld_ip_i | input | 16 | IP value for a load |
| ld_sp_i | input | 16 | SP value for a load |
| ld_flags_i | input | 16 | FLAGS value for a load |
| ss_i | input | 16 | stack segment |
| req_i | input | 1 | operation request |
| req_op_i | input | 3 | operation code |
| req_vec_i | input | 8 | vector number for operation code 0 |
| req_nip_i | input | 16 | address of the next instruction |
| bnd_val_i | input | 16 | signed value for the bound check |
| bnd_seg_i | input | 16 | segment of the bound pair |
| bnd_off_i | input | 16 | offset of the bound pair |
| eirq_i | input | 1 | external maskable interrupt |
| eirq_vec_i | input | 8 | vector of the external interrupt |
| mem_req_o | output | 1 | memory access request |
| mem_we_o | output | 1 | access is a write |
| mem_addr_o | output | 20 | byte address |
| mem_wdata_o | output | 16 | write data |
| mem_rdata_i | input | 16 | read data, valid with ready |
| mem_rdy_i | input | 1 | access completes this cycle |
| cs_o | output | 16 | code segment |
| ip_o | output | 16 | instruction pointer |
| sp_o | output | 16 | stack pointer |
| flags_o | output | 16 | flags word |
| busy_o | output | 1 | sequence in progress |
| done_o | output | 1 | operation finished (one cycle) |

## Verification
The bench builds the block with its default parameters: 16-bit words, 20-bit addresses, 8-bit vector numbers, and the flag bit positions and trap vectors given above. With these values the bench can reach the highest vector (255, at the top of the 1 KiB table) and a stack pointer of zero, whose first push wraps to offset 0xFFFE. The bench also switches between a memory with no wait states and one that answers only one cycle in three. The signed bound pair spans zero, so the exact boundary values pass and the values one step outside each end trap.

// File: rtl/rm_int_pkg.sv
package rm_int_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PSH_F, S_PSH_CS, S_PSH_IP, S_VEC_IP, S_VEC_CS,
    S_POP_IP, S_POP_CS, S_POP_F, S_BND_LO, S_BND_HI
  } st_e;

  typedef enum logic [2:0] {
    OP_INT = 3'd0, OP_BRK = 3'd1, OP_OVF = 3'd2, OP_BND = 3'd3,
    OP_RET = 3'd4, OP_STI = 3'd5, OP_CLI = 3'd6, OP_NOP = 3'd7
  } op_e;
endpackage

// File: rtl/rm_phys_addr.sv
module rm_phys_addr #(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input  logic [DW-1:0] seg_i,
  input  logic [DW-1:0] off_i,
  output logic [AW-1:0] addr_o
);
  localparam int SW = DW + 4;
  logic [SW-1:0] sum;
  assign sum    = {seg_i, 4'h0} + {4'h0, off_i};
  assign addr_o = sum[AW-1:0];
endmodule

// File: rtl/rm_bound_check.sv
module rm_bound_check #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          out_o
);
  assign out_o = ($signed(val_i) < $signed(lo_i)) || ($signed(val_i) > $signed(hi_i));
endmodule

// File: rtl/rm_flag_reg.sv
module rm_flag_reg #(
  parameter int              DW      = 16,
  parameter int              TF_BIT  = 8,
  parameter int              IF_BIT  = 9,
  parameter logic [DW-1:0]   RST_VAL = 16'h0002
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          clr_ti_i,
  input  logic          if_set_i,
  input  logic          if_clr_i,
  output logic [DW-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= RST_VAL;
    end else if (ld_i) begin
      flags_o <= ld_val_i;
    end else if (clr_ti_i) begin
      flags_o[TF_BIT] <= 1'b0;
      flags_o[IF_BIT] <= 1'b0;
    end else if (if_set_i) begin
      flags_o[IF_BIT] <= 1'b1;
    end else if (if_clr_i) begin
      flags_o[IF_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/rm_int_unit.sv
module rm_int_unit
  import rm_int_pkg::*;
#(
  parameter int            DW      = 16,
  parameter int            AW      = 20,
  parameter int            VW      = 8,
  parameter int            TF_BIT  = 8,
  parameter int            IF_BIT  = 9,
  parameter int            OF_BIT  = 11,
  parameter int            BRK_VEC = 3,
  parameter int            OVF_VEC = 4,
  parameter int            BND_VEC = 5,
  parameter logic [DW-1:0] RST_CS  = 16'hFFFF,
  parameter logic [DW-1:0] RST_IP  = 16'h0000,
  parameter logic [DW-1:0] RST_SP  = 16'h0000,
  parameter logic [DW-1:0] RST_FL  = 16'h0002
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_cs_i,
  input  logic [DW-1:0] ld_ip_i,
  input  logic [DW-1:0] ld_sp_i,
  input  logic [DW-1:0] ld_flags_i,
  input  logic [DW-1:0] ss_i,
  input  logic          req_i,
  input  logic [2:0]    req_op_i,
  input  logic [VW-1:0] req_vec_i,
  input  logic [DW-1:0] req_nip_i,
  input  logic [DW-1:0] bnd_val_i,
  input  logic [DW-1:0] bnd_seg_i,
  input  logic [DW-1:0] bnd_off_i,
  input  logic          eirq_i,
  input  logic [VW-1:0] eirq_vec_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] flags_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int            VSH  = 2;            // four bytes per vector
  localparam logic [DW-1:0] WB_V = DW'(DW / 8);  // bytes per word
  localparam int            PADW = DW - VW - VSH;

  st_e           st_q, st_d;
  logic [DW-1:0] cs_q, ip_q, sp_q;
  logic [VW-1:0] vec_q;
  logic [DW-1:0] bseg_q, boff_q, bval_q, blo_q;
  logic          done_q, done_d;
  logic [DW-1:0] flags;

  logic          idle, xfer;
  logic          acc_ld, acc_req, acc_irq;
  op_e           op;
  logic          bnd_out;
  logic [DW-1:0] seg_sel, off_sel, vec_off;

  logic          fl_ld, fl_clr_ti, fl_if_set, fl_if_clr;
  logic [DW-1:0] fl_ld_val;

  assign idle    = (st_q == S_IDLE);
  assign xfer    = mem_req_o & mem_rdy_i;
  assign op      = op_e'(req_op_i);
  assign acc_ld  = idle & ld_i;
  assign acc_req = idle & ~ld_i & req_i;
  assign acc_irq = idle & ~ld_i & ~req_i & eirq_i & flags[IF_BIT];
  assign vec_off = {{PADW{1'b0}}, vec_q, {VSH{1'b0}}};

  rm_bound_check #(.DW(DW)) u_bnd (
    .val_i (bval_q),
    .lo_i  (blo_q),
    .hi_i  (mem_rdata_i),
    .out_o (bnd_out)
  );

  rm_flag_reg #(.DW(DW), .TF_BIT(TF_BIT), .IF_BIT(IF_BIT), .RST_VAL(RST_FL)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (fl_ld),
    .ld_val_i (fl_ld_val),
    .clr_ti_i (fl_clr_ti),
    .if_set_i (fl_if_set),
    .if_clr_i (fl_if_clr),
    .flags_o  (flags)
  );

  rm_phys_addr #(.DW(DW), .AW(AW)) u_addr (
    .seg_i  (seg_sel),
    .off_i  (off_sel),
    .addr_o (mem_addr_o)
  );

  // address source per state
  always_comb begin
    seg_sel = '0;
    off_sel = '0;
    unique case (st_q)
      S_PSH_F, S_PSH_CS, S_PSH_IP: begin
        seg_sel = ss_i;
        off_sel = sp_q - WB_V;
      end
      S_POP_IP, S_POP_CS, S_POP_F: begin
        seg_sel = ss_i;
        off_sel = sp_q;
      end
      S_VEC_IP: off_sel = vec_off;
      S_VEC_CS: off_sel = vec_off + WB_V;
      S_BND_LO: begin
        seg_sel = bseg_q;
        off_sel = boff_q;
      end
      S_BND_HI: begin
        seg_sel = bseg_q;
        off_sel = boff_q + WB_V;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (st_q)
      S_PSH_F:  mem_wdata_o = flags;
      S_PSH_CS: mem_wdata_o = cs_q;
      S_PSH_IP: mem_wdata_o = ip_q;
      default:  mem_wdata_o = '0;
    endcase
  end

  assign mem_req_o = ~idle;
  assign mem_we_o  = (st_q == S_PSH_F) | (st_q == S_PSH_CS) | (st_q == S_PSH_IP);

  // next state and flag controls
  always_comb begin
    st_d      = st_q;
    done_d    = 1'b0;
    fl_ld     = 1'b0;
    fl_ld_val = ld_flags_i;
    fl_clr_ti = 1'b0;
    fl_if_set = 1'b0;
    fl_if_clr = 1'b0;
    if (acc_ld) begin
      fl_ld = 1'b1;
    end else if (acc_req) begin
      unique case (op)
        OP_INT, OP_BRK: st_d = S_PSH_F;
        OP_OVF: begin
          if (flags[OF_BIT]) st_d = S_PSH_F;
          else               done_d = 1'b1;
        end
        OP_BND: st_d = S_BND_LO;
        OP_RET: st_d = S_POP_IP;
        OP_STI: begin
          fl_if_set = 1'b1;
          done_d    = 1'b1;
        end
        OP_CLI: begin
          fl_if_clr = 1'b1;
          done_d    = 1'b1;
        end
        default: ;
      endcase
    end else if (acc_irq) begin
      st_d = S_PSH_F;
    end else if (xfer) begin
      unique case (st_q)
        S_PSH_F: begin
          st_d      = S_PSH_CS;
          fl_clr_ti = 1'b1;
        end
        S_PSH_CS: st_d = S_PSH_IP;
        S_PSH_IP: st_d = S_VEC_IP;
        S_VEC_IP: st_d = S_VEC_CS;
        S_VEC_CS: begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end
        S_POP_IP: st_d = S_POP_CS;
        S_POP_CS: st_d = S_POP_F;
        S_POP_F: begin
          st_d      = S_IDLE;
          done_d    = 1'b1;
          fl_ld     = 1'b1;
          fl_ld_val = mem_rdata_i;
        end
        S_BND_LO: st_d = S_BND_HI;
        S_BND_HI: begin
          if (bnd_out) begin
            st_d = S_PSH_F;
          end else begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= RST_CS;
      ip_q   <= RST_IP;
      sp_q   <= RST_SP;
      vec_q  <= '0;
      bseg_q <= '0;
      boff_q <= '0;
      bval_q <= '0;
      blo_q  <= '0;
    end else if (acc_ld) begin
      cs_q <= ld_cs_i;
      ip_q <= ld_ip_i;
      sp_q <= ld_sp_i;
    end else if (acc_req) begin
      if (op != OP_RET && op != OP_NOP) ip_q <= req_nip_i;
      unique case (op)
        OP_BRK:  vec_q <= VW'(BRK_VEC);
        OP_OVF:  vec_q <= VW'(OVF_VEC);
        OP_BND:  vec_q <= VW'(BND_VEC);
        default: vec_q <= req_vec_i;
      endcase
      bseg_q <= bnd_seg_i;
      boff_q <= bnd_off_i;
      bval_q <= bnd_val_i;
    end else if (acc_irq) begin
      vec_q <= eirq_vec_i;
    end else if (xfer) begin
      unique case (st_q)
        S_PSH_F, S_PSH_CS, S_PSH_IP: sp_q <= sp_q - WB_V;
        S_POP_IP: begin
          ip_q <= mem_rdata_i;
          sp_q <= sp_q + WB_V;
        end
        S_POP_CS: begin
          cs_q <= mem_rdata_i;
          sp_q <= sp_q + WB_V;
        end
        S_POP_F:  sp_q  <= sp_q + WB_V;
        S_VEC_IP: ip_q  <= mem_rdata_i;
        S_VEC_CS: cs_q  <= mem_rdata_i;
        S_BND_LO: blo_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign sp_o    = sp_q;
  assign flags_o = flags;
  assign busy_o  = ~idle;
  assign done_o  = done_q;
endmodule

// File: rtl/rm_int_unit_chk.sv
module rm_int_unit_chk #(
  parameter int DW     = 16,
  parameter int AW     = 20,
  parameter int TF_BIT = 8,
  parameter int IF_BIT = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rdy_i,
  input logic [DW-1:0] cs_o,
  input logic [DW-1:0] ip_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] flags_o,
  input logic          busy_o,
  input logic          done_o
);
  localparam logic [DW-1:0] WB_V = DW'(DW / 8);

  a_r9_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  a_r2_push_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rdy_i && mem_we_o |=> sp_o == $past(sp_o) - WB_V);

  a_r3_ti_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rdy_i && mem_we_o |=> !flags_o[TF_BIT] && !flags_o[IF_BIT]);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(mem_req_o && mem_rdy_i) |=> $stable(cs_o) && $stable(ip_o) && $stable(sp_o));
endmodule

bind rm_int_unit rm_int_unit_chk #(.DW(DW), .AW(AW), .TF_BIT(TF_BIT), .IF_BIT(IF_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdy_i   (mem_rdy_i),
  .cs_o        (cs_o),
  .ip_o        (ip_o),
  .sp_o        (sp_o),
  .flags_o     (flags_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/sim_rm_int_unit.sv
`timescale 1ns/1ps
module sim_rm_int_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [15:0] ld_cs = '0, ld_ip = '0, ld_sp = '0, ld_fl = '0;
  logic [15:0] ss = 16'h2000;
  logic        req = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_vec = '0;
  logic [15:0] req_nip = '0, bval = '0, bseg = '0, boff = '0;
  logic        eirq = 1'b0;
  logic [7:0]  eirq_vec = '0;
  logic        mreq, mwe;
  logic [19:0] maddr;
  logic [15:0] mwdata;
  logic [15:0] mrdata = '0;
  logic        mrdy = 1'b0;
  logic [15:0] cs, ip, sp, fl;
  logic        busy, done;

  always #2.5 clk = ~clk;

  rm_int_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_i(ld), .ld_cs_i(ld_cs), .ld_ip_i(ld_ip), .ld_sp_i(ld_sp), .ld_flags_i(ld_fl),
    .ss_i(ss), .req_i(req), .req_op_i(req_op), .req_vec_i(req_vec), .req_nip_i(req_nip),
    .bnd_val_i(bval), .bnd_seg_i(bseg), .bnd_off_i(boff),
    .eirq_i(eirq), .eirq_vec_i(eirq_vec),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_rdy_i(mrdy),
    .cs_o(cs), .ip_o(ip), .sp_o(sp), .flags_o(fl), .busy_o(busy), .done_o(done)
  );

  typedef struct {
    logic        we;
    logic [19:0] addr;
    logic [15:0] wd;
    string       tag;
  } xact_t;

  xact_t       expq[$];
  logic [15:0] mem [int];
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  bit          stall = 1'b0;
  logic [15:0] m_cs, m_ip, m_sp, m_fl;

  function automatic logic [15:0] rd(int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic int phys(logic [15:0] s, logic [15:0] o);
    return ((int'(s) << 4) + int'(o)) & 32'hFFFFF;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory responder and transfer comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    mrdy   = stall ? (cyc % 3 == 0) : 1'b1;
    mrdata = rd(int'(maddr));
    if (rst_n && mreq && mrdy) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10 unexpected transfer", {12'h0, maddr}, 32'h0);
      end else begin
        xact_t e;
        e = expq.pop_front();
        check(mwe == e.we, {e.tag, " dir"}, {31'h0, mwe}, {31'h0, e.we});
        check(maddr == e.addr, {e.tag, " addr"}, {12'h0, maddr}, {12'h0, e.addr});
        if (e.we) check(mwdata == e.wd, {e.tag, " data"}, {16'h0, mwdata}, {16'h0, e.wd});
      end
      if (mwe) mem[int'(maddr)] = mwdata;
    end
  end

  task automatic exp_push(string tag, logic [15:0] v);
    m_sp = m_sp - 16'd2;
    expq.push_back('{1'b1, 20'(phys(ss, m_sp)), v, tag});
  endtask

  task automatic exp_read(string tag, int a);
    expq.push_back('{1'b0, 20'(a), 16'h0, tag});
  endtask

  task automatic model_entry(int v, logic [15:0] pip);
    exp_push("R2 R3 push flags", m_fl);
    m_fl = m_fl & ~16'h0300;
    exp_push("R2 push cs", m_cs);
    exp_push("R2 push ip", pip);
    exp_read("R1 vector ip", v * 4);
    exp_read("R1 vector cs", v * 4 + 2);
    m_ip = rd(v * 4);
    m_cs = rd(v * 4 + 2);
  endtask

  task automatic check_regs(string tag);
    check(cs == m_cs, {tag, " cs"}, {16'h0, cs}, {16'h0, m_cs});
    check(ip == m_ip, {tag, " ip"}, {16'h0, ip}, {16'h0, m_ip});
    check(sp == m_sp, {tag, " sp"}, {16'h0, sp}, {16'h0, m_sp});
    check(fl == m_fl, {tag, " flags"}, {16'h0, fl}, {16'h0, m_fl});
  endtask

  task automatic pulse(logic [2:0] o, logic [7:0] v, logic [15:0] nip);
    @(negedge clk);
    req = 1'b1; req_op = o; req_vec = v; req_nip = nip;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {tag, " R10 done seen"}, {31'h0, done}, 32'h1);
    check(expq.size() == 0, {tag, " all transfers seen"}, expq.size(), 32'h0);
    expq.delete();
    check_regs(tag);
    @(negedge clk);
    check(done == 1'b0, {tag, " R10 done one cycle"}, {31'h0, done}, 32'h0);
  endtask

  task automatic load(logic [15:0] c, logic [15:0] i, logic [15:0] s, logic [15:0] f);
    @(negedge clk);
    ld = 1'b1; ld_cs = c; ld_ip = i; ld_sp = s; ld_fl = f;
    @(negedge clk);
    ld = 1'b0;
    m_cs = c; m_ip = i; m_sp = s; m_fl = f;
    check_regs("R11 load");
  endtask

  task automatic run_int(logic [7:0] v, logic [15:0] nip);
    model_entry(v, nip);
    pulse(3'd0, v, nip);
    wait_done("R1 R2 int");
  endtask

  task automatic run_ret();
    exp_read("R7 pop ip", phys(ss, m_sp));
    m_ip = rd(phys(ss, m_sp)); m_sp += 16'd2;
    exp_read("R7 pop cs", phys(ss, m_sp));
    m_cs = rd(phys(ss, m_sp)); m_sp += 16'd2;
    exp_read("R7 pop flags", phys(ss, m_sp));
    m_fl = rd(phys(ss, m_sp)); m_sp += 16'd2;
    pulse(3'd4, 8'h00, 16'h0);
    wait_done("R7 return");
  endtask

  task automatic run_bnd(logic [15:0] v, logic [15:0] nip);
    logic [15:0] lo, hi;
    lo = rd(phys(bseg, boff));
    hi = rd(phys(bseg, boff + 16'd2));
    exp_read("R6 lower", phys(bseg, boff));
    exp_read("R6 upper", phys(bseg, boff + 16'd2));
    bval = v;
    if ($signed(v) < $signed(lo) || $signed(v) > $signed(hi)) model_entry(5, nip);
    else m_ip = nip;
    pulse(3'd3, 8'h00, nip);
    wait_done("R6 bound");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < 256; v++) begin
      mem[v * 4]     = 16'h1000 + 16'(v * 16);
      mem[v * 4 + 2] = 16'h3000 + 16'(v);
    end
    bseg = 16'h5000; boff = 16'h0010;
    mem[phys(bseg, boff)]         = 16'hFFF0;
    mem[phys(bseg, boff + 16'd2)] = 16'h0010;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_cs = 16'hFFFF; m_ip = 16'h0; m_sp = 16'h0; m_fl = 16'h0002;
    check_regs("R11 reset");
    check(busy == 1'b0 && mreq == 1'b0, "R11 reset idle", {30'h0, busy, mreq}, 32'h0);

    load(16'h1234, 16'h0100, 16'h0200, 16'h0302);
    run_int(8'h21, 16'h0102);
    run_ret();   // R7: trace and enable restored

    stall = 1'b1;
    run_int(8'hFF, 16'h0150);   // R1 top vector, R9 with waits
    run_ret();

    model_entry(3, 16'h0161);   // R4: vector input is ignored
    pulse(3'd1, 8'h77, 16'h0161);
    wait_done("R4 breakpoint");
    run_ret();
    stall = 1'b0;

    load(16'h1234, 16'h0170, 16'h0200, 16'h0002);
    m_ip = 16'h0172;            // R5 no trap
    pulse(3'd2, 8'h00, 16'h0172);
    wait_done("R5 overflow clear");
    load(16'h1234, 16'h0180, 16'h0200, 16'h0802);
    model_entry(4, 16'h0181);
    pulse(3'd2, 8'h00, 16'h0181);
    wait_done("R5 overflow set");
    run_ret();

    run_bnd(16'h0005, 16'h0190);  // R6 inside
    run_bnd(16'hFFF0, 16'h0194);  // R6 lower edge
    run_bnd(16'h0010, 16'h0198);  // R6 upper edge
    run_bnd(16'h0011, 16'h019C);  // R6 above
    run_ret();
    stall = 1'b1;
    run_bnd(16'hFFEF, 16'h01A0);  // R6 below
    run_ret();
    stall = 1'b0;

    m_fl = m_fl | 16'h0200; m_ip = 16'h01B0;
    pulse(3'd5, 8'h00, 16'h01B0);
    wait_done("R8 set enable");
    model_entry(8'h40, m_ip);     // R8 external, current IP pushed
    @(negedge clk);
    eirq = 1'b1; eirq_vec = 8'h40;
    @(negedge clk);
    eirq = 1'b0;
    wait_done("R8 external");
    run_ret();
    m_fl = m_fl & ~16'h0200; m_ip = 16'h01C0;
    pulse(3'd6, 8'h00, 16'h01C0);
    wait_done("R8 clear enable");
    eirq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(busy == 1'b0, "R8 masked external", {31'h0, busy}, 32'h0);
    end
    eirq = 1'b0;

    // R10: requests while busy are dropped
    stall = 1'b1;
    model_entry(8'h21, 16'h01D0);
    pulse(3'd0, 8'h21, 16'h01D0);
    @(negedge clk);
    req = 1'b1; req_op = 3'd5; ld = 1'b1; ld_cs = 16'hDEAD; ld_sp = 16'h0BAD; eirq = 1'b1;
    @(negedge clk);
    req = 1'b0; ld = 1'b0; eirq = 1'b0;
    wait_done("R10 busy ignore");
    run_ret();
    stall = 1'b0;

    pulse(3'd7, 8'h12, 16'h0EEE);  // R12
    for (int i = 0; i < 3; i++) begin
      check(busy == 1'b0 && done == 1'b0, "R12 ignored op", {30'h0, busy, done}, 32'h0);
      @(negedge clk);
    end
    check_regs("R12 ignored op");

    load(16'h4000, 16'h0010, 16'h0000, 16'h0202);  // R2 stack wrap
    run_int(8'h05, 16'h0012);
    run_ret();

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule